// File: doc/BRIEF.md
# Control-Flow Next-PC Unit

This block decides where instruction fetch goes after a control instruction. It takes the already-incremented program counter, the 16-bit instruction word, the three one-hot condition flags (negative, zero, positive) and the contents of a general register. From these it produces the next program counter and a flag saying that the sequential path was left. Everything is combinational; the caller latches `next_pc` into its PC register on the following clock edge.

Three instruction kinds are recognised. A conditional branch tests a three-bit mask against the flags and, when any selected flag is set, adds a sign-extended nine-bit offset to the incremented PC. A register jump takes its target straight from the supplied register value, whose index the block presents on `base_sel`. A service call presents an eight-bit vector, zero-extended, as a table address for the fetch stage to read, and it offers the incremented PC as the return link. All other opcodes fall through to the incremented PC.

Top module: `nextpc_unit`

## Requirements
- R1: Opcode `instr[15:12]` = 4'b0000 is a conditional branch; mask bit `instr[11]` selects N, `instr[10]` selects Z, `instr[9]` selects P, with `flags` = {N,Z,P}; the branch is taken when (mask AND flags) is non-zero.
- R2: A branch whose mask is 3'b000 is never taken, whatever the flags.
- R3: A branch whose mask is 3'b111 is taken whenever exactly one flag is set.
- R4: A taken branch drives `next_pc` = `pc_inc` + sign-extended `instr[8:0]`, modulo 2^16, and `taken` = 1.
- R5: A branch that is not taken drives `next_pc` = `pc_inc` and `taken` = 0.
- R6: Opcode 4'b1100 is a register jump: `taken` = 1 and `next_pc` = `base_val`; for every instruction `base_sel` = `instr[8:6]`.
- R7: Opcode 4'b1111 is a service call: `trap_req` = 1, `trap_addr` = {8'h00, `instr[7:0]`}, `taken` = 0 and `next_pc` = `pc_inc`; for other opcodes `trap_req` = 0 and `trap_addr` = 0.
- R8: A service call sets `link_we` = 1 with `link_pc` = `pc_inc`; every other opcode gives `link_we` = 0.
- R9: Any opcode other than 0000, 1100 and 1111 gives `taken` = 0, `trap_req` = 0 and `next_pc` = `pc_inc`.
- R10: All outputs follow the inputs in the same cycle with no internal state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_inc | input | 16 | Program counter already advanced past the current instruction |
| instr | input | 16 | Current instruction word |
| flags | input | 3 | Condition flags {N,Z,P}, one-hot |
| base_val | input | 16 | Contents of the register named by `base_sel` |
| base_sel | output | 3 | Register index for the jump base, `instr[8:6]` |
| next_pc | output | 16 | Address the fetch stage uses next |
| taken | output | 1 | Control left the sequential path through `next_pc` |
| trap_req | output | 1 | Service call; fetch must read the table entry |
| trap_addr | output | 16 | Zero-extended service vector |
| link_we | output | 1 | Write the return address |
| link_pc | output | 16 | Return address for a service call |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between the ports. The bench changes inputs just after a rising edge and compares all outputs with a behavioural model at the following falling edge, half a period later, so each check sees settled values of one stimulus only. Directed cases cover every mask against every flag, offset extremes that wrap the address space, the three example vectors and all non-control opcodes, followed by a pseudo-random sweep.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;

    localparam int OPC_W   = 4;
    localparam int MASK_W  = 3;
    localparam int REG_W   = 3;
    localparam int VEC_W   = 8;
    localparam int OFF_W   = 9;

    localparam logic [OPC_W-1:0] OPC_BRANCH = 4'b0000;
    localparam logic [OPC_W-1:0] OPC_JUMP   = 4'b1100;
    localparam logic [OPC_W-1:0] OPC_SVC    = 4'b1111;

    typedef enum logic [1:0] {
        KIND_SEQ    = 2'd0,
        KIND_BRANCH = 2'd1,
        KIND_JUMP   = 2'd2,
        KIND_SVC    = 2'd3
    } ctl_kind_e;

    typedef struct packed {
        ctl_kind_e           kind;
        logic [MASK_W-1:0]   mask;
        logic [REG_W-1:0]    base;
        logic [VEC_W-1:0]    vec;
        logic [OFF_W-1:0]    off;
    } ctl_fields_t;

endpackage

// File: rtl/nextpc_decode.sv
module nextpc_decode
    import nextpc_pkg::*;
#(
    parameter int XLEN = 16
) (
    input  logic [XLEN-1:0] instr,
    output ctl_fields_t     fields
);

    localparam int OPC_LSB  = XLEN - OPC_W;
    localparam int MASK_LSB = OPC_LSB - MASK_W;
    localparam int BASE_LSB = MASK_LSB - REG_W;

    logic [OPC_W-1:0] opc;

    always_comb begin
        opc          = instr[XLEN-1:OPC_LSB];
        fields.mask  = instr[OPC_LSB-1:MASK_LSB];
        fields.base  = instr[MASK_LSB-1:BASE_LSB];
        fields.vec   = instr[VEC_W-1:0];
        fields.off   = instr[OFF_W-1:0];
        unique case (opc)
            OPC_BRANCH: fields.kind = KIND_BRANCH;
            OPC_JUMP:   fields.kind = KIND_JUMP;
            OPC_SVC:    fields.kind = KIND_SVC;
            default:    fields.kind = KIND_SEQ;
        endcase
    end

endmodule

// File: rtl/nextpc_cond.sv
module nextpc_cond
    import nextpc_pkg::*;
(
    input  logic [MASK_W-1:0] mask,
    input  logic [MASK_W-1:0] flags,
    output logic              hit
);

    logic [MASK_W-1:0] sel;

    for (genvar i = 0; i < MASK_W; i++) begin : g_sel
        assign sel[i] = mask[i] & flags[i];
    end

    assign hit = |sel;

endmodule

// File: rtl/nextpc_target.sv
module nextpc_target
    import nextpc_pkg::*;
#(
    parameter int XLEN = 16
) (
    input  logic [XLEN-1:0]  pc_inc,
    input  logic [OFF_W-1:0] off,
    output logic [XLEN-1:0]  target
);

    localparam int EXT_W = XLEN - OFF_W;

    logic [XLEN-1:0] off_ext;

    always_comb begin
        off_ext = {{EXT_W{off[OFF_W-1]}}, off};
        target  = pc_inc + off_ext;
    end

endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
    import nextpc_pkg::*;
#(
    parameter int XLEN = 16
) (
    input  logic [XLEN-1:0]   pc_inc,
    input  logic [XLEN-1:0]   instr,
    input  logic [MASK_W-1:0] flags,
    input  logic [XLEN-1:0]   base_val,
    output logic [REG_W-1:0]  base_sel,
    output logic [XLEN-1:0]   next_pc,
    output logic              taken,
    output logic              trap_req,
    output logic [XLEN-1:0]   trap_addr,
    output logic              link_we,
    output logic [XLEN-1:0]   link_pc
);

    localparam int VEC_PAD = XLEN - VEC_W;

    typedef struct packed {
        logic [XLEN-1:0] next_pc;
        logic            taken;
        logic            trap_req;
        logic [XLEN-1:0] trap_addr;
        logic            link_we;
        logic [XLEN-1:0] link_pc;
    } result_t;

    ctl_fields_t     fields;
    logic            cond_hit;
    logic [XLEN-1:0] br_target;
    result_t         res_d;

    nextpc_decode #(.XLEN(XLEN)) u_decode (
        .instr  (instr),
        .fields (fields)
    );

    nextpc_cond u_cond (
        .mask  (fields.mask),
        .flags (flags),
        .hit   (cond_hit)
    );

    nextpc_target #(.XLEN(XLEN)) u_target (
        .pc_inc (pc_inc),
        .off    (fields.off),
        .target (br_target)
    );

    always_comb begin
        res_d           = '0;
        res_d.next_pc   = pc_inc;
        unique case (fields.kind)
            KIND_BRANCH: begin
                if (cond_hit) begin
                    res_d.next_pc = br_target;
                    res_d.taken   = 1'b1;
                end
            end
            KIND_JUMP: begin
                res_d.next_pc = base_val;
                res_d.taken   = 1'b1;
            end
            KIND_SVC: begin
                res_d.trap_req  = 1'b1;
                res_d.trap_addr = {{VEC_PAD{1'b0}}, fields.vec};
                res_d.link_we   = 1'b1;
                res_d.link_pc   = pc_inc;
            end
            default: ;
        endcase
    end

    assign base_sel  = fields.base;
    assign next_pc   = res_d.next_pc;
    assign taken     = res_d.taken;
    assign trap_req  = res_d.trap_req;
    assign trap_addr = res_d.trap_addr;
    assign link_we   = res_d.link_we;
    assign link_pc   = res_d.link_pc;

endmodule

// File: rtl/nextpc_unit_chk.sv
module nextpc_unit_chk #(
    parameter int XLEN = 16
) (
    input logic [XLEN-1:0] pc_inc,
    input logic [XLEN-1:0] instr,
    input logic [2:0]      flags,
    input logic [XLEN-1:0] base_val,
    input logic [XLEN-1:0] next_pc,
    input logic            taken,
    input logic            trap_req,
    input logic [XLEN-1:0] trap_addr,
    input logic            link_we,
    input logic [XLEN-1:0] link_pc
);

    logic [3:0] opc;
    logic [2:0] msk;
    logic       known;

    always_comb begin
        opc   = instr[XLEN-1:XLEN-4];
        msk   = instr[XLEN-5:XLEN-7];
        known = !$isunknown({instr, flags, pc_inc, base_val});
        if (known) begin
            if (opc == 4'b0000 && msk == 3'b000)
                assert_mask_none_R2: assert (!taken && next_pc == pc_inc);
            if (opc == 4'b0000 && msk == 3'b111 && $onehot(flags))
                assert_mask_all_R3: assert (taken);
            if (opc == 4'b0000 && !taken)
                assert_fallthru_R5: assert (next_pc == pc_inc);
            if (opc == 4'b1100)
                assert_jump_R6: assert (taken && next_pc == base_val);
            if (trap_req)
                assert_vector_R7: assert (trap_addr[XLEN-1:8] == '0 && !taken && next_pc == pc_inc);
            if (link_we)
                assert_link_R8: assert (trap_req && link_pc == pc_inc);
            if (opc != 4'b0000 && opc != 4'b1100 && opc != 4'b1111)
                assert_seq_R9: assert (!taken && !trap_req && next_pc == pc_inc);
        end
    end

endmodule

bind nextpc_unit nextpc_unit_chk #(.XLEN(XLEN)) u_chk (
    .pc_inc    (pc_inc),
    .instr     (instr),
    .flags     (flags),
    .base_val  (base_val),
    .next_pc   (next_pc),
    .taken     (taken),
    .trap_req  (trap_req),
    .trap_addr (trap_addr),
    .link_we   (link_we),
    .link_pc   (link_pc)
);

// File: tb/nextpc_unit_test.sv
module nextpc_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pc_inc = '0;
    logic [15:0] instr = '0;
    logic [2:0]  flags = '0;
    logic [15:0] base_val = '0;
    logic [2:0]  base_sel;
    logic [15:0] next_pc;
    logic        taken;
    logic        trap_req;
    logic [15:0] trap_addr;
    logic        link_we;
    logic [15:0] link_pc;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #2.5 clk = ~clk;

    nextpc_unit uut (
        .pc_inc    (pc_inc),
        .instr     (instr),
        .flags     (flags),
        .base_val  (base_val),
        .base_sel  (base_sel),
        .next_pc   (next_pc),
        .taken     (taken),
        .trap_req  (trap_req),
        .trap_addr (trap_addr),
        .link_we   (link_we),
        .link_pc   (link_pc)
    );

    function automatic logic [31:0] rnd();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return lfsr;
    endfunction

    task automatic cmp(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Behavioural model evaluated from the requirement text.
    task automatic apply(string tag, logic [15:0] p, logic [15:0] i,
                         logic [2:0] f, logic [15:0] b);
        int e_next, e_taken, e_trap, e_taddr, e_lwe, e_lpc, off;
        @(posedge clk);
        #1;
        pc_inc = p; instr = i; flags = f; base_val = b;
        e_next = p; e_taken = 0; e_trap = 0; e_taddr = 0; e_lwe = 0; e_lpc = 0;
        if (i[15:12] == 4'd0) begin
            if ((i[11:9] & f) != 0) begin
                off = i[8] ? int'(i[8:0]) - 512 : int'(i[8:0]);
                e_next = (int'(p) + off) & 16'hFFFF;
                e_taken = 1;
            end
        end else if (i[15:12] == 4'd12) begin
            e_next = b; e_taken = 1;
        end else if (i[15:12] == 4'd15) begin
            e_trap = 1; e_taddr = i[7:0]; e_lwe = 1; e_lpc = p;
        end
        @(negedge clk);
        cmp(tag, "next_pc", next_pc, e_next);
        cmp(tag, "taken", taken, e_taken);
        cmp(tag, "trap_req", trap_req, e_trap);
        cmp(tag, "trap_addr", trap_addr, e_taddr);
        cmp(tag, "link_we", link_we, e_lwe);
        if (e_lwe) cmp(tag, "link_pc", link_pc, e_lpc);
        cmp("R6", "base_sel", base_sel, i[8:6]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R10: all-zero inputs settle to the sequential value at once
        @(negedge clk);
        cmp("R10", "reset next_pc", next_pc, 16'h0000);
        cmp("R10", "reset taken", taken, 0);
        cmp("R10", "reset trap_req", trap_req, 0);

        // R1, R2, R3, R4, R5: every mask against every one-hot flag
        for (int m = 0; m < 8; m++) begin
            for (int k = 0; k < 3; k++) begin
                apply((m == 0) ? "R2" : (m == 7) ? "R3" : "R1",
                      16'h3005, {4'b0000, m[2:0], 9'h004}, 3'b001 << k, 16'h0);
            end
        end
        // R4: offset extremes and wrap-around
        apply("R4", 16'h3000, {4'b0000, 3'b111, 9'h0FF}, 3'b010, 16'h0);
        apply("R4", 16'h3000, {4'b0000, 3'b111, 9'h100}, 3'b100, 16'h0);
        apply("R4", 16'hFFF0, {4'b0000, 3'b001, 9'h020}, 3'b001, 16'h0);
        apply("R4", 16'h0005, {4'b0000, 3'b010, 9'h1F0}, 3'b010, 16'h0);
        // R5: not taken with a large offset keeps pc_inc
        apply("R5", 16'h4321, {4'b0000, 3'b100, 9'h0FF}, 3'b001, 16'h0);
        // R6: register jump
        apply("R6", 16'h3001, {4'b1100, 3'b000, 3'b101, 6'h00}, 3'b100, 16'hBEEF);
        apply("R6", 16'h3001, {4'b1100, 3'b000, 3'b010, 6'h00}, 3'b010, 16'h0000);
        // R7, R8: service calls with sample vectors
        apply("R7", 16'h3010, {4'b1111, 4'h0, 8'h23}, 3'b010, 16'h1111);
        apply("R7", 16'h3011, {4'b1111, 4'h0, 8'h21}, 3'b100, 16'h1111);
        apply("R8", 16'h3012, {4'b1111, 4'h0, 8'h25}, 3'b001, 16'h1111);
        apply("R8", 16'hFFFF, {4'b1111, 4'hF, 8'hFF}, 3'b001, 16'h1111);
        // R9: every other opcode falls through
        for (int o = 1; o < 15; o++) begin
            if (o != 12)
                apply("R9", 16'h2222, {o[3:0], 12'hFFF}, 3'b010, 16'h7777);
        end
        // R10: random sweep, one stimulus per cycle
        for (int n = 0; n < 400; n++) begin
            logic [31:0] a, c;
            a = rnd();
            c = rnd();
            apply("R10", a[15:0], a[31:16], 3'b001 << (c[1:0] % 3), c[31:16]);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule